// File: doc/BRIEF.md
# Snapshot Timestamp Capture Controller

This block freezes a coherent picture of several free-running time counters so that software can read them over a 32-bit register bus. The counters are an always-running cycle timer, a wall clock, a sample counter driven by a DMA strobe, and one 64-bit event counter per link. Software writes a control word that picks a link, a DMA channel and type, and a word select for the second wall-clock snapshot. It then sets one of two capture triggers. The on-demand trigger captures one clock later. The event trigger waits for the chosen link's strobe.

When the capture happens, the trigger bit drops and a completion flag rises. While the flag is set, no further capture can load the snapshot registers. Every 64-bit value can therefore be read as two 32-bit words without tearing. Software releases the snapshot by writing 1 to the flag.

Top module: `tstamp_capture_unit`

## Requirements
- R1: After reset, every register reads 0, including the control word with its completion flag, both trigger bits and all snapshot words.
- R2: Control bits 30, 13:12, 11:10, 6 and 4:0 are plain read/write. The other bits, except 31, 7 and 5, read 0 regardless of what is written.
- R3: Writing the control word with bit 5 set and bit 7 clear starts an on-demand capture, and bit 5 reads 1 while the capture is pending. At the next clock edge the capture happens: bit 5 clears and bit 31 (the completion flag) sets on that same edge.
- R4: Writing bit 7 set and bit 5 clear starts an event capture. Bit 7 stays pending until a clock edge at which `link_strobe[link select]` is high, where link select is bits 11:10. The capture takes place on that edge.
- R5: A control write with both bits 7 and 5 set latches neither trigger, and no capture follows.
- R6: A capture stores the counter values held just before the capturing edge. The timer holds the number of edges since reset. The wall clock holds that number times `WALL_INC`. The sample count holds the number of edges at which `dma_strobe` was high. The link count holds the number of edges at which the selected link's strobe was high.
- R7: The second wall-clock snapshot holds the low 32 bits of the wall clock when control bit 6 is 0, and the high 32 bits when bit 6 is 1.
- R8: The completion flag clears only when bit 31 is written as 1; writing 0 leaves it set. While the flag is set, all snapshot words keep their values.
- R9: A trigger written while the flag is set reads back as pending but does not capture. Capture occurs at the edge after the edge that clears the flag.
- R10: The word addresses are as follows: 0 is control, 1 is sample count, 2 and 3 are link count (low word then high word), 4 and 5 are wall clock, 6 and 7 are the timer, and 8 is the second wall clock. Any other address reads 0.
- R11: A trigger written while another capture is pending is ignored; the pending trigger is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the control word (address 0) |
| bus_addr | input | 4 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| dma_strobe | input | 1 | Sample event, counted on each high edge |
| link_strobe | input | NUM_LINKS | Per-link frame strobes |

## Verification
The hardest case to reach is a trigger that arrives while an earlier snapshot is still held. The capture must then wait, and must land exactly one edge after the flag is cleared. The bench gets there by leaving the flag set, writing a trigger, idling several cycles, and then clearing the flag. It checks that the snapshot kept its old contents up to that point and then took the counters from the edge after the clear. For the event trigger, the chosen link's strobe is masked while the other links keep toggling. One strobe is then forced, so the capture edge and the expected link count are known exactly.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int CTRL_W = 32;
  localparam int BIT_DONE  = 31;
  localparam int BIT_HWTRG = 7;
  localparam int BIT_CSEL  = 6;
  localparam int BIT_ODTRG = 5;
  localparam int LSEL_LO   = 10;
  localparam int LSEL_W    = 2;
  localparam logic [CTRL_W-1:0] RW_MASK = 32'h4000_3C5F;

  typedef enum logic [3:0] {
    A_CTRL = 4'd0, A_SMP = 4'd1, A_LNK_LO = 4'd2, A_LNK_HI = 4'd3,
    A_WALL_LO = 4'd4, A_WALL_HI = 4'd5, A_ART_LO = 4'd6, A_ART_HI = 4'd7,
    A_WALL2 = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic [31:0] smp;
    logic [63:0] lnk;
    logic [63:0] wall;
    logic [63:0] art;
    logic [31:0] wall2;
  } snap_t;

  function automatic logic single_trigger(logic hw, logic od);
    return hw ^ od;
  endfunction

  function automatic logic [63:0] wall_advance(logic [63:0] w, logic [63:0] inc);
    return w + inc;
  endfunction

  function automatic logic [31:0] wall_word(logic [63:0] w, logic hi);
    return hi ? w[63:32] : w[31:0];
  endfunction
endpackage

// File: rtl/tsc_counters.sv
module tsc_counters #(
  parameter int NUM_LINKS = 4,
  parameter logic [63:0] WALL_INC = 64'h0000_0001_0000_0003
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_strobe,
  input  logic [NUM_LINKS-1:0] link_strobe,
  output logic [63:0] art_cnt,
  output logic [63:0] wall_cnt,
  output logic [31:0] smp_cnt,
  output logic [NUM_LINKS-1:0][63:0] lnk_cnt
);
  import tsc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      art_cnt  <= '0;
      wall_cnt <= '0;
      smp_cnt  <= '0;
    end else begin
      art_cnt  <= art_cnt + 64'd1;
      wall_cnt <= wall_advance(wall_cnt, WALL_INC);
      if (dma_strobe) smp_cnt <= smp_cnt + 32'd1;
    end
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lnk_cnt[g] <= '0;
      else if (link_strobe[g]) lnk_cnt[g] <= lnk_cnt[g] + 64'd1;
    end
  end
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl #(
  parameter int NUM_LINKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic [31:0] wdata,
  input  logic [NUM_LINKS-1:0] link_strobe,
  output logic [31:0] ctrl_rd,
  output logic fire,
  output logic csel,
  output logic [1:0] lsel
);
  import tsc_pkg::*;

  logic [31:0] cfg_q;
  logic od_pend, hw_pend, done_q;
  logic link_hit, trig_ok, idle;

  assign lsel = cfg_q[LSEL_LO +: LSEL_W];
  assign csel = cfg_q[BIT_CSEL];

  always_comb begin
    link_hit = 1'b0;
    for (int i = 0; i < NUM_LINKS; i++)
      if (lsel == 2'(i)) link_hit = link_strobe[i];
  end

  assign trig_ok = single_trigger(wdata[BIT_HWTRG], wdata[BIT_ODTRG]);
  assign idle    = !od_pend && !hw_pend;
  assign fire    = !done_q && (od_pend || (hw_pend && link_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      od_pend <= 1'b0;
      hw_pend <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (wr_ctrl) cfg_q <= wdata & RW_MASK;
      if (fire) begin
        od_pend <= 1'b0;
        hw_pend <= 1'b0;
      end else if (wr_ctrl && trig_ok && idle) begin
        od_pend <= wdata[BIT_ODTRG];
        hw_pend <= wdata[BIT_HWTRG];
      end
      if (fire) done_q <= 1'b1;
      else if (wr_ctrl && wdata[BIT_DONE]) done_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd = cfg_q;
    ctrl_rd[BIT_DONE]  = done_q;
    ctrl_rd[BIT_HWTRG] = hw_pend;
    ctrl_rd[BIT_ODTRG] = od_pend;
  end

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(od_pend && hw_pend));
  assert_od_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (od_pend && !done_q) |=> (!od_pend && done_q));
  assert_hw_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_pend && !link_hit) |=> hw_pend);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (od_pend || hw_pend)) |=> (od_pend || hw_pend));
  assert_w0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(wr_ctrl && wdata[BIT_DONE])) |=> done_q);
endmodule

// File: rtl/tsc_snapshot.sv
module tsc_snapshot #(
  parameter int NUM_LINKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic csel,
  input  logic [1:0] lsel,
  input  logic [63:0] art_cnt,
  input  logic [63:0] wall_cnt,
  input  logic [31:0] smp_cnt,
  input  logic [NUM_LINKS-1:0][63:0] lnk_cnt,
  output tsc_pkg::snap_t snap
);
  import tsc_pkg::*;

  logic [63:0] lnk_sel;

  always_comb begin
    lnk_sel = '0;
    for (int i = 0; i < NUM_LINKS; i++)
      if (lsel == 2'(i)) lnk_sel = lnk_cnt[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap <= '0;
    else if (fire) begin
      snap.smp   <= smp_cnt;
      snap.lnk   <= lnk_sel;
      snap.wall  <= wall_cnt;
      snap.art   <= art_cnt;
      snap.wall2 <= wall_word(wall_cnt, csel);
    end
  end
endmodule

// File: rtl/tstamp_capture_unit.sv
module tstamp_capture_unit #(
  parameter int NUM_LINKS = 4,
  parameter logic [63:0] WALL_INC = 64'h0000_0001_0000_0003
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_we,
  input  logic [3:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic dma_strobe,
  input  logic [NUM_LINKS-1:0] link_strobe
);
  import tsc_pkg::*;

  logic [63:0] art_cnt, wall_cnt;
  logic [31:0] smp_cnt;
  logic [NUM_LINKS-1:0][63:0] lnk_cnt;
  logic [31:0] ctrl_rd;
  logic fire, csel;
  logic [1:0] lsel;
  logic wr_ctrl;
  snap_t snap;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);

  tsc_counters #(.NUM_LINKS(NUM_LINKS), .WALL_INC(WALL_INC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .dma_strobe(dma_strobe), .link_strobe(link_strobe),
    .art_cnt(art_cnt), .wall_cnt(wall_cnt), .smp_cnt(smp_cnt), .lnk_cnt(lnk_cnt));

  tsc_ctrl #(.NUM_LINKS(NUM_LINKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .link_strobe(link_strobe), .ctrl_rd(ctrl_rd), .fire(fire), .csel(csel), .lsel(lsel));

  tsc_snapshot #(.NUM_LINKS(NUM_LINKS)) u_snap (
    .clk(clk), .rst_n(rst_n), .fire(fire), .csel(csel), .lsel(lsel),
    .art_cnt(art_cnt), .wall_cnt(wall_cnt), .smp_cnt(smp_cnt), .lnk_cnt(lnk_cnt),
    .snap(snap));

  always_comb begin
    case (bus_addr)
      A_CTRL:    bus_rdata = ctrl_rd;
      A_SMP:     bus_rdata = snap.smp;
      A_LNK_LO:  bus_rdata = snap.lnk[31:0];
      A_LNK_HI:  bus_rdata = snap.lnk[63:32];
      A_WALL_LO: bus_rdata = snap.wall[31:0];
      A_WALL_HI: bus_rdata = snap.wall[63:32];
      A_ART_LO:  bus_rdata = snap.art[31:0];
      A_ART_HI:  bus_rdata = snap.art[63:32];
      A_WALL2:   bus_rdata = snap.wall2;
      default:   bus_rdata = '0;
    endcase
  end

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[BIT_DONE] |=> $stable(snap));
  assert_capture_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ctrl_rd[BIT_DONE]);
endmodule

// File: tb/tstamp_capture_unit_tb.sv
module tstamp_capture_unit_tb;
  localparam logic [63:0] INC = 64'h0000_0001_0000_0003;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic dma_strobe;
  logic [3:0] link_strobe;

  logic [7:0] gen_q = 8'h5A;
  logic [3:0] link_mask = '0;
  logic [3:0] link_force = '0;
  assign dma_strobe  = gen_q[7];
  assign link_strobe = (gen_q[3:0] & ~link_mask) | link_force;

  int n_run = 0, n_fail = 0;
  longint unsigned cyc = 0, smp = 0;
  longint unsigned lnk [4] = '{0, 0, 0, 0};

  tstamp_capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_strobe(dma_strobe), .link_strobe(link_strobe));

  always #10 clk = ~clk;

  always @(negedge clk) gen_q <= {gen_q[6:0], gen_q[7] ^ gen_q[5] ^ gen_q[4] ^ gen_q[3]};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; smp <= 0;
      for (int i = 0; i < 4; i++) lnk[i] <= 0;
    end else begin
      cyc <= cyc + 1;
      if (dma_strobe) smp <= smp + 1;
      for (int i = 0; i < 4; i++) if (link_strobe[i]) lnk[i] <= lnk[i] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd64(input logic [3:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 4'd1, hi); d = {hi, lo};
  endtask

  function automatic logic [31:0] mk(bit clr, bit hw, bit od, bit cs, int ls);
    logic [31:0] v;
    v = 32'h4000_2003;
    v[31] = clr; v[7] = hw; v[5] = od; v[6] = cs; v[11:10] = 2'(ls);
    return v;
  endfunction

  task automatic check_snap(input string req, input longint unsigned e_art,
                            input longint unsigned e_smp, input longint unsigned e_lnk,
                            input bit cs);
    logic [63:0] v; logic [31:0] w; logic [63:0] e_wall;
    e_wall = 64'(e_art) * INC;
    rd64(4'd6, v); chk(v == 64'(e_art), {req, " R6 timer"}, v, e_art);
    rd64(4'd4, v); chk(v == e_wall, {req, " R6 wall"}, v, e_wall);
    rd(4'd1, w);   chk(w == 32'(e_smp), {req, " R6 sample"}, w, e_smp);
    rd64(4'd2, v); chk(v == 64'(e_lnk), {req, " R6 link"}, v, e_lnk);
    rd(4'd8, w);
    chk(w == (cs ? e_wall[63:32] : e_wall[31:0]), {req, " R7 wall2"}, w,
        cs ? e_wall[63:32] : e_wall[31:0]);
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    longint unsigned ea, es, el;
    repeat (3) @(negedge clk);
    // R1 / R10: reset values on all addresses, unmapped reads 0
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), r); chk(r == 0, "R1 reset value", r, 0);
    end
    rst_n = 1'b1;

    // R2: read/write fields
    wr(32'h4F00_3F5F); rd(4'd0, r); chk(r == 32'h4000_3C5F, "R2 rw fields", r, 32'h4000_3C5F);
    wr(32'h0000_0000); rd(4'd0, r); chk(r == 32'h0, "R2 clear fields", r, 0);

    // R5: both triggers together ignored
    wr(mk(0, 1, 1, 0, 1)); rd(4'd0, r);
    chk(r[7] == 0 && r[5] == 0, "R5 no trigger latched", r, mk(0, 0, 0, 0, 1));
    repeat (4) @(negedge clk);
    rd(4'd0, r); chk(r[31] == 0, "R5 no capture", r[31], 0);
    rd(4'd6, r); chk(r == 0, "R5 snapshot untouched", r, 0);

    // R3 on-demand capture
    wr(mk(0, 0, 1, 0, 1));
    ea = cyc; es = smp; el = lnk[1];
    rd(4'd0, r); chk(r[5] == 1 && r[31] == 0, "R3 pending", r, mk(0, 0, 1, 0, 1));
    @(negedge clk);
    rd(4'd0, r); chk(r[5] == 0 && r[31] == 1, "R3 done with trigger clear", r, 32'h8000_0000);
    check_snap("R3", ea, es, el, 0);

    // R8 write 0 to flag, freeze; R9 trigger while flag set
    wr(mk(0, 0, 0, 0, 1));
    rd(4'd0, r); chk(r[31] == 1, "R8 write0 keeps flag", r[31], 1);
    wr(mk(0, 0, 1, 1, 1));
    repeat (5) @(negedge clk);
    rd(4'd0, r); chk(r[5] == 1 && r[31] == 1, "R9 pending held while flag set", r, 32'hC000_2463);
    check_snap("R8 frozen", ea, es, el, 0);
    wr(mk(1, 0, 0, 1, 1));
    ea = cyc; es = smp; el = lnk[1];
    rd(4'd0, r); chk(r[31] == 0 && r[5] == 1, "R9 flag cleared trigger kept", r, 32'h4000_2463);
    @(negedge clk);
    rd(4'd0, r); chk(r[31] == 1 && r[5] == 0, "R9 capture after clear", r, 32'hC000_2443);
    check_snap("R9", ea, es, el, 1);

    // R4 event capture on link 2, R11 second trigger ignored
    wr(mk(1, 0, 0, 0, 0));
    link_mask = 4'b0100;
    wr(mk(0, 1, 0, 1, 2));
    repeat (6) @(negedge clk);
    rd(4'd0, r); chk(r[7] == 1 && r[31] == 0, "R4 waits for strobe", r, mk(0, 1, 0, 1, 2));
    wr(mk(0, 0, 1, 1, 2));
    rd(4'd0, r); chk(r[7] == 1 && r[5] == 0, "R11 second trigger ignored", r, mk(0, 1, 0, 1, 2));
    @(negedge clk);
    ea = cyc; es = smp; el = lnk[2];
    link_force = 4'b0100;
    @(negedge clk);
    link_force = 4'b0000;
    rd(4'd0, r); chk(r[7] == 0 && r[31] == 1, "R4 captured on strobe", r, 32'hC000_2843);
    check_snap("R4", ea, es, el, 1);
    link_mask = 4'b0000;

    // Sweep link select and word select with on-demand captures
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        wr(mk(1, 0, 0, c[0], s));
        wr(mk(0, 0, 1, c[0], s));
        ea = cyc; es = smp; el = lnk[s];
        @(negedge clk);
        check_snap("R6 R7 sweep", ea, es, el, c[0]);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule